// File: doc/BRIEF.md
# Single-Clock FIFO with Rewind and Programmable Thresholds

This block buffers 9-bit words between a producer and a consumer that share one clock. Both sides are qualified by active-low enables: every rising edge on which the write enable is low stores a word, unless the buffer is full. Every rising edge on which the read enable is low moves the oldest word into a registered output, unless the buffer is empty. Four active-low flags report the occupancy: empty, full, nearly-empty and nearly-full. The two "nearly" thresholds are offsets held in small registers. They return to 7 on reset and can be reloaded through the write port while a load strobe is held low.

A rewind input sets the read pointer back to storage slot zero. Everything written since reset can then be read again, followed by anything written later. This lets a receiver ask for a packet to be sent again. An output-enable decides whether the registered word is presented. A companion drive-enable output marks when the data bus is driven, and it stands in for a high-impedance state.

Top module: `sfifo_rt`

## Requirements
- R1: Each clock edge with `wr_en_n` low stores `din` (when not full), and each edge with `rd_en_n` low loads the oldest stored word into the data register (when not empty); words leave in the order they entered, and a read and a write in the same cycle are both performed.
- R2: `empty_n` is low exactly when 0 words are held and `full_n` is low exactly when DEPTH words are held.
- R3: `aempty_n` is low exactly when the occupancy is at most the empty offset n.
- R4: `afull_n` is low exactly when the occupancy is at least DEPTH minus the full offset m.
- R5: Reset (`rst_n` low) empties the FIFO, clears the data register to 0, drives `empty_n` and `aempty_n` low and `full_n` and `afull_n` high, and sets both offsets to 7.
- R6: A write while full and a read while empty are ignored: occupancy, flags and `dout` stay unchanged.
- R7: A cycle with `rt` high moves the read pointer to slot 0 and sets the occupancy to the number of words written since reset (at most DEPTH). Read and write enables are ignored in that cycle.
- R8: After a rewind, reads return the words written since reset in their original order, then the words written after the rewind. A full DEPTH of words may be rewound and read again repeatedly.
- R9: With `ld_n` low, a write-enabled cycle loads `din[CW-1:0]` into an offset register instead of the FIFO. Here CW = clog2(DEPTH+1). The first such cycle loads the empty offset n, the second loads the full offset m, and the two then alternate.
- R10: When `oe_n` is low, `dout` equals the data register and `dout_en` is 1. When `oe_n` is high, `dout` is 0 and `dout_en` is 0.
- R11: The first word written into an empty FIFO can be read in the cycle right after `empty_n` goes high, and it appears on `dout` after that read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| ld_n | input | 1 | Active-low offset load strobe |
| rt | input | 1 | Active-high rewind of the read pointer |
| oe_n | input | 1 | Active-low output enable |
| din | input | WIDTH | Write data, or offset value while loading |
| dout | output | WIDTH | Registered read data, 0 when not enabled |
| dout_en | output | 1 | High when `dout` is driven |
| empty_n | output | 1 | Low when empty |
| full_n | output | 1 | Low when full |
| aempty_n | output | 1 | Low when occupancy is at most n |
| afull_n | output | 1 | Low when occupancy is at least DEPTH minus m |

## Verification
The assertions check, on every cycle, the invariants that need no stored data: the occupancy bound, occupancy moving by at most one word outside a rewind, a full or empty buffer holding its state, the rewind landing on slot 0, the alternation of the offset selector, and that the flags are consistent with each other. Only the bench scenarios can show data order through wrap-around, the exact occupancy bands for loaded offsets, and the replayed content after partial and full-depth rewinds. They also cover the return to default offsets after a second reset and the first-word latency.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    typedef enum logic {
        SEL_EMPTY_OFS = 1'b0,
        SEL_FULL_OFS  = 1'b1
    } ofs_sel_e;

    localparam int unsigned DEF_OFFSET = 7;
endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = $clog2(DEPTH),
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          rt,
    output logic          wr_fire,
    output logic          rd_fire,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] count
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          seen;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        wr_fire = wr_req && !rt && (st_q.cnt != FULL);
        rd_fire = rd_req && !rt && (st_q.cnt != '0);
        if (rt) begin
            st_d.rp  = '0;
            st_d.cnt = (st_q.wp == '0 && st_q.seen) ? FULL : CW'(st_q.wp);
        end else begin
            if (wr_fire) begin
                st_d.wp   = (st_q.wp == LAST) ? '0 : st_q.wp + AW'(1);
                st_d.seen = 1'b1;
            end
            if (rd_fire) begin
                st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + AW'(1);
            end
            if (wr_fire && !rd_fire) begin
                st_d.cnt = st_q.cnt + CW'(1);
            end else if (rd_fire && !wr_fire) begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr = st_q.wp;
    assign rd_addr = st_q.rp;
    assign count   = st_q.cnt;

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);

    assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL && !rd_req && !rt) |=> st_q.cnt == FULL);

    assert_empty_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !wr_req && !rt) |=> st_q.cnt == '0);

    assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rt |=> (st_q.cnt == $past(st_q.cnt) ||
                 st_q.cnt == $past(st_q.cnt) + CW'(1) ||
                 st_q.cnt == $past(st_q.cnt) - CW'(1)));

    assert_rewind_slot0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rt |=> st_q.rp == '0);

    assert_rewind_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rt && st_q.seen) |=> st_q.cnt != '0);
endmodule

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
    parameter int unsigned WIDTH = 9,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [WIDTH-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            slot_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_d = re ? slot_q[raddr] : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata_q));
endmodule

// File: rtl/sfifo_offs.sv
module sfifo_offs
    import sfifo_pkg::*;
#(
    parameter int unsigned OW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_wr,
    input  logic [OW-1:0] value,
    output logic [OW-1:0] n_ofs,
    output logic [OW-1:0] m_ofs
);
    typedef struct packed {
        ofs_sel_e      sel;
        logic [OW-1:0] n;
        logic [OW-1:0] m;
    } offs_t;

    localparam offs_t RST_VAL = '{sel: SEL_EMPTY_OFS, n: OW'(DEF_OFFSET), m: OW'(DEF_OFFSET)};

    offs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_wr) begin
            if (st_q.sel == SEL_EMPTY_OFS) begin
                st_d.n   = value;
                st_d.sel = SEL_FULL_OFS;
            end else begin
                st_d.m   = value;
                st_d.sel = SEL_EMPTY_OFS;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign n_ofs = st_q.n;
    assign m_ofs = st_q.m;

    assert_load_alternates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> st_q.sel != $past(st_q.sel));

    assert_idle_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_wr |=> ($stable(st_q.n) && $stable(st_q.m)));
endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] n_ofs,
    input  logic [CW-1:0] m_ofs,
    output logic          empty_n,
    output logic          full_n,
    output logic          aempty_n,
    output logic          afull_n
);
    localparam logic [CW:0] FULL_X = (CW+1)'(DEPTH);

    logic [CW:0] reach;

    always_comb begin
        reach    = {1'b0, count} + {1'b0, m_ofs};
        empty_n  = (count != '0);
        full_n   = ({1'b0, count} != FULL_X);
        aempty_n = !(count <= n_ofs);
        afull_n  = !(reach >= FULL_X);
    end
endmodule

// File: rtl/sfifo_rt.sv
module sfifo_rt #(
    parameter int unsigned WIDTH = 9,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_n,
    input  logic             rd_en_n,
    input  logic             ld_n,
    input  logic             rt,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dout_en,
    output logic             empty_n,
    output logic             full_n,
    output logic             aempty_n,
    output logic             afull_n
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic          wr_req, rd_req, load_wr;
    logic          wr_fire, rd_fire;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [CW-1:0] count, n_ofs, m_ofs;
    logic [WIDTH-1:0] rdata;

    assign wr_req  = !wr_en_n && ld_n;
    assign rd_req  = !rd_en_n;
    assign load_wr = !wr_en_n && !ld_n && !rt;

    sfifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req), .rt(rt),
        .wr_fire(wr_fire), .rd_fire(rd_fire),
        .wr_addr(wr_addr), .rd_addr(rd_addr), .count(count)
    );

    sfifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_fire), .waddr(wr_addr), .wdata(din),
        .re(rd_fire), .raddr(rd_addr), .rdata(rdata)
    );

    sfifo_offs #(.OW(CW)) u_offs (
        .clk(clk), .rst_n(rst_n), .load_wr(load_wr), .value(din[CW-1:0]),
        .n_ofs(n_ofs), .m_ofs(m_ofs)
    );

    sfifo_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .count(count), .n_ofs(n_ofs), .m_ofs(m_ofs),
        .empty_n(empty_n), .full_n(full_n), .aempty_n(aempty_n), .afull_n(afull_n)
    );

    assign dout    = oe_n ? '0 : rdata;
    assign dout_en = !oe_n;

    assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!empty_n && !full_n));

    assert_empty_implies_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    assert_full_implies_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    assert_load_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && rd_en_n && !rt) |=> $stable(count));
endmodule

// File: tb/sim_sfifo_rt.sv
module sim_sfifo_rt;
    localparam int W = 9;
    localparam int D = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en_n = 1'b1, rd_en_n = 1'b1, ld_n = 1'b1, rt = 1'b0, oe_n = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic dout_en, empty_n, full_n, aempty_n, afull_n;

    int checks = 0;
    int failures = 0;

    int q[$];
    int hist[$];
    int n_exp, m_exp, dexp;
    bit lsel;

    always #5 clk = ~clk;

    sfifo_rt #(.WIDTH(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .ld_n(ld_n),
        .rt(rt), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en),
        .empty_n(empty_n), .full_n(full_n), .aempty_n(aempty_n), .afull_n(afull_n)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
        end
    endtask

    task automatic chk_all(input string req);
        int s;
        s = q.size();
        chk("R2", {req, " empty_n"}, int'(empty_n), int'(s != 0));
        chk("R2", {req, " full_n"}, int'(full_n), int'(s != D));
        chk("R3", {req, " aempty_n"}, int'(aempty_n), int'(!(s <= n_exp)));
        chk("R4", {req, " afull_n"}, int'(afull_n), int'(!(s >= D - m_exp)));
        chk("R10", {req, " dout"}, int'(dout), oe_n ? 0 : dexp);
        chk("R10", {req, " dout_en"}, int'(dout_en), int'(!oe_n));
    endtask

    task automatic tick(input bit w, input bit r, input bit l, input bit t, input int d);
        bit rdok, wrok;
        @(negedge clk);
        wr_en_n = !w; rd_en_n = !r; ld_n = !l; rt = t; din = W'(d);
        @(posedge clk);
        #1;
        wr_en_n = 1'b1; rd_en_n = 1'b1; ld_n = 1'b1; rt = 1'b0;
        if (t) begin
            q = hist;
        end else begin
            rdok = r && q.size() > 0;
            wrok = w && !l && q.size() < D;
            if (w && l) begin
                if (!lsel) n_exp = d % (1 << 5); else m_exp = d % (1 << 5);
                lsel = !lsel;
            end
            if (rdok) dexp = q.pop_front();
            if (wrok) begin
                q.push_back(d % (1 << W));
                hist.push_back(d % (1 << W));
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en_n = 1'b1; rd_en_n = 1'b1; ld_n = 1'b1; rt = 1'b0;
        q.delete(); hist.delete();
        n_exp = 7; m_exp = 7; dexp = 0; lsel = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic fill_drain(input string tag, input int seed);
        for (int i = 0; i < D; i++) begin
            tick(1, 0, 0, 0, (i * 37 + seed) % 512);
            chk_all({tag, " fill R1"});
        end
        tick(1, 0, 0, 0, 9'h1AA);
        chk_all({tag, " write-when-full R6"});
        for (int i = 0; i < D; i++) begin
            tick(0, 1, 0, 0, 0);
            chk_all({tag, " drain R1"});
        end
        tick(0, 1, 0, 0, 0);
        chk_all({tag, " read-when-empty R6"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        chk_all("reset R5");

        fill_drain("default", 5);

        // R11: first-word latency
        tick(1, 0, 0, 0, 9'h0C3);
        chk("R11", "empty_n after first write", int'(empty_n), 1);
        tick(0, 1, 0, 0, 0);
        chk("R11", "first word on dout", int'(dout), 9'h0C3);
        chk_all("latency R11");

        // R9: offset load, empty offset then full offset
        tick(1, 0, 1, 0, 3);
        chk_all("load n R9");
        tick(1, 0, 1, 0, 2);
        chk_all("load m R9");
        chk("R9", "no FIFO write while loading", int'(empty_n), 0);
        fill_drain("loaded", 11);

        // R5: second reset restores default offsets
        do_reset();
        chk_all("re-reset R5");
        fill_drain("after reset", 200);

        // R1: simultaneous read and write mid-occupancy
        for (int i = 0; i < 5; i++) tick(1, 0, 0, 0, 50 + i);
        for (int i = 0; i < 6; i++) begin
            tick(1, 1, 0, 0, 80 + i);
            chk_all("rd+wr R1");
        end

        // R7/R8: partial rewind
        do_reset();
        for (int i = 0; i < 10; i++) tick(1, 0, 0, 0, 300 + 7 * i);
        for (int i = 0; i < 4; i++) begin
            tick(0, 1, 0, 0, 0);
            chk_all("pre-rewind read R1");
        end
        tick(1, 1, 0, 1, 9'h155);
        chk_all("rewind, enables ignored R7");
        tick(1, 0, 0, 0, 400);
        tick(1, 0, 0, 0, 401);
        for (int i = 0; i < 12; i++) begin
            tick(0, 1, 0, 0, 0);
            chk_all("replay R8");
        end

        // R8: full-depth rewind, repeated
        do_reset();
        for (int i = 0; i < D; i++) tick(1, 0, 0, 0, 100 + 13 * i);
        for (int i = 0; i < D; i++) tick(0, 1, 0, 0, 0);
        chk_all("drained before rewind R8");
        for (int k = 0; k < 2; k++) begin
            tick(0, 0, 0, 1, 0);
            chk_all("full rewind R7");
            for (int i = 0; i < D; i++) begin
                tick(0, 1, 0, 0, 0);
                chk_all("full replay R8");
            end
        end

        // R10: output enable
        @(negedge clk);
        oe_n = 1'b1;
        #1;
        chk_all("oe off R10");
        @(negedge clk);
        oe_n = 1'b0;
        #1;
        chk_all("oe on R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule